// File: doc/BRIEF.md
# Closed-Loop PRBS Duty Perturbation Injector

This block sits between a digital current controller and the PWM modulator of a linear electronic load. On every control sample it adds a small pseudo-random square-wave offset to the controller's duty command. The loop stays closed while the plant is excited with a broadband test signal, so the plant's transfer function can later be identified from logged input and output records. The sign of the offset comes from a 9-bit maximal-length shift register that steps once per sample. The offset size is set at run time, typically to about one twentieth of the full duty range. The sum is clamped to the legal duty range.

The current sequence bit is brought out next to the perturbed duty so that a data logger can record the excitation alongside the measured response. When injection is switched off, the controller's command passes through unchanged and the sequence freezes in place.

Top module: `prbs_injector`

## Requirements
- R1: After reset the shift register holds the all-ones seed (9'h1FF), so `prbs_bit` reads 1 before the first step.
- R2: On a clock edge where `sample_stb` and `inj_en` are both high, the 9-bit state s advances to {s[7:0], s[8]^s[4]} (polynomial x^9 + x^5 + 1), and `prbs_bit` always shows s[8]. The state is never all zeros.
- R3: With injection enabled and a strobe every sample, the bit sequence repeats every 511 samples and holds exactly 256 ones per period.
- R4: While enabled, a sequence bit of 1 makes `duty_out` equal `duty_in + amp`.
- R5: While enabled, a sequence bit of 0 makes `duty_out` equal `duty_in - amp`.
- R6: While enabled, a sum above FULL_SCALE (default 4000) is clamped to FULL_SCALE, and `duty_out` never exceeds FULL_SCALE.
- R7: While enabled, a sum below zero is clamped to 0.
- R8: When `inj_en` is low, `duty_out` equals `duty_in` exactly and the sequence state is held even if `sample_stb` pulses. After re-enable, the sequence resumes from where it stopped.
- R9: With `inj_en` high but no `sample_stb`, the sequence state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_in | input | DUTY_W (12) | Duty command from the current controller |
| sample_stb | input | 1 | One-cycle pulse per control sample |
| inj_en | input | 1 | Injection enable |
| amp | input | DUTY_W (12) | Perturbation amplitude in duty counts |
| duty_out | output | DUTY_W (12) | Perturbed, clamped duty to the modulator |
| prbs_bit | output | 1 | Current excitation bit for logging |

## Verification
A long run of back-to-back strobes with a mid-range command and a small amplitude checks that the sequence is correct, that the offset has the right sign, and that the sequence repeats every 511 samples with 256 ones. Commands near the top and bottom of the range, with an amplitude large enough to cross the limits, separate correct clamping from wraparound. Strobes with the enable low, and enabled cycles with no strobe, show whether the sequence holds or slips, and the bits that follow show whether it resumes from the right place. A command above full scale shows that the clamp also covers out-of-range inputs.

// File: rtl/prbs_inj_pkg.sv
package prbs_inj_pkg;
  localparam int LFSR_W = 9;
  localparam int TAP_HI = 9;
  localparam int TAP_LO = 5;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // one Fibonacci step of x^9 + x^5 + 1, shifting toward the msb
  function automatic lfsr_t lfsr_advance(input lfsr_t s);
    logic fb;
    fb = s[TAP_HI-1] ^ s[TAP_LO-1];
    return {s[LFSR_W-2:0], fb};
  endfunction
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
  import prbs_inj_pkg::*;
#(
  parameter lfsr_t SEED = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  output lfsr_t state,
  output logic  out_bit
);
  lfsr_t state_q;
  lfsr_t state_nx;

  assign state_nx = lfsr_advance(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= SEED;
    else if (state_q == '0)
      state_q <= SEED;        // recovery from a corrupted state
    else if (advance)
      state_q <= state_nx;
  end

  assign state   = state_q;
  assign out_bit = state_q[LFSR_W-1];
endmodule

// File: rtl/prbs_offset_sat.sv
module prbs_offset_sat #(
  parameter int DUTY_W     = 12,
  parameter int FULL_SCALE = 4000
) (
  input  logic [DUTY_W-1:0] base,
  input  logic [DUTY_W-1:0] amp,
  input  logic              add_pos,
  output logic [DUTY_W-1:0] result,
  output logic              sat_hi,
  output logic              sat_lo
);
  localparam int SUM_W = DUTY_W + 2;
  localparam logic signed [SUM_W-1:0] FULL_S = SUM_W'(FULL_SCALE);

  function automatic logic signed [SUM_W-1:0] signed_sum(
    input logic [DUTY_W-1:0] b,
    input logic [DUTY_W-1:0] a,
    input logic              pos
  );
    logic signed [SUM_W-1:0] bs, as_;
    bs  = $signed({2'b00, b});
    as_ = $signed({2'b00, a});
    return pos ? (bs + as_) : (bs - as_);
  endfunction

  logic signed [SUM_W-1:0] raw;

  always_comb begin
    raw    = signed_sum(base, amp, add_pos);
    sat_lo = raw < 0;
    sat_hi = raw > FULL_S;
    if (sat_lo)      result = '0;
    else if (sat_hi) result = DUTY_W'(FULL_SCALE);
    else             result = raw[DUTY_W-1:0];
  end
endmodule

// File: rtl/prbs_injector.sv
module prbs_injector
  import prbs_inj_pkg::*;
#(
  parameter int    DUTY_W     = 12,
  parameter int    FULL_SCALE = 4000,
  parameter lfsr_t SEED       = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              sample_stb,
  input  logic              inj_en,
  input  logic [DUTY_W-1:0] amp,
  output logic [DUTY_W-1:0] duty_out,
  output logic              prbs_bit
);
  lfsr_t             lfsr_q;
  logic              step_ev;
  logic              sat_hi;
  logic              sat_lo;
  logic [DUTY_W-1:0] perturbed;

  assign step_ev = sample_stb & inj_en;

  prbs_lfsr #(.SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (step_ev),
    .state   (lfsr_q),
    .out_bit (prbs_bit)
  );

  prbs_offset_sat #(.DUTY_W(DUTY_W), .FULL_SCALE(FULL_SCALE)) u_sat (
    .base    (duty_in),
    .amp     (amp),
    .add_pos (prbs_bit),
    .result  (perturbed),
    .sat_hi  (sat_hi),
    .sat_lo  (sat_lo)
  );

  assign duty_out = inj_en ? perturbed : duty_in;
endmodule

// File: rtl/prbs_injector_chk.sv
module prbs_injector_chk
  import prbs_inj_pkg::*;
#(
  parameter int DUTY_W     = 12,
  parameter int FULL_SCALE = 4000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DUTY_W-1:0] duty_in,
  input logic              inj_en,
  input logic [DUTY_W-1:0] amp,
  input logic [DUTY_W-1:0] duty_out,
  input logic              prbs_bit,
  input lfsr_t             lfsr_q,
  input logic              step_ev,
  input logic              sat_hi,
  input logic              sat_lo
);
  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> prbs_bit == $past(lfsr_q[LFSR_W-2]));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ev |=> $stable(lfsr_q));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> duty_out == duty_in);

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> duty_out <= DUTY_W'(FULL_SCALE));

  // R4
  plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && prbs_bit && !sat_hi) |->
      ({2'b00, duty_out} == {2'b00, duty_in} + {2'b00, amp}));

  // R5
  minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && !prbs_bit && !sat_lo && !sat_hi) |->
      ({2'b00, duty_out} + {2'b00, amp} == {2'b00, duty_in}));

  // R7
  low_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && sat_lo) |-> duty_out == '0);
endmodule

bind prbs_injector prbs_injector_chk #(.DUTY_W(DUTY_W), .FULL_SCALE(FULL_SCALE)) u_chk (.*);

// File: tb/tb_prbs_injector.sv
module tb_prbs_injector;
  localparam int DW   = 12;
  localparam int FULL = 4000;

  typedef struct {
    int    duty;
    bit    pbit;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] duty_in = '0;
  logic          sample_stb = 1'b0;
  logic          inj_en = 1'b0;
  logic [DW-1:0] amp = '0;
  logic [DW-1:0] duty_out;
  logic          prbs_bit;

  int   checks = 0;
  int   failures = 0;
  exp_t q[$];
  bit [8:0] model = 9'h1FF;   // R1 seed
  bit   rec[0:519];

  always #2 clk = ~clk;

  prbs_injector dut (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .sample_stb(sample_stb),
    .inj_en(inj_en), .amp(amp), .duty_out(duty_out), .prbs_bit(prbs_bit)
  );

  function automatic int ref_duty(int base, int a, bit up);
    int v;
    if (up) v = base + a;
    else    v = base - a;
    if (v > FULL) v = FULL;
    else if (v < 0) v = 0;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic drive(input int d, input int a, input bit stb, input bit en, input string tag);
    exp_t e;
    @(negedge clk);
    duty_in = DW'(d); amp = DW'(a); sample_stb = stb; inj_en = en;
    e.pbit = model[8];
    e.duty = en ? ref_duty(d, a, model[8]) : d;
    e.tag  = tag;
    q.push_back(e);
    if (stb && en) model = {model[7:0], model[8] ^ model[4]};
  endtask

  // monitor: compares one cycle of outputs midway between edges
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(int'(duty_out) == e.duty, {e.tag, " duty"}, int'(duty_out), e.duty);
        check(prbs_bit == e.pbit, {e.tag, " bit"}, int'(prbs_bit), int'(e.pbit));
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R8 bypass while disabled
    drive(100, 50, 0, 0, "R1 R8 reset");
    drive(1234, 300, 1, 0, "R8 strobe ignored");
    drive(77, 300, 1, 0, "R8 strobe ignored");
    drive(2000, 100, 0, 0, "R1 bit still seed");

    // R2 R3 R4 R5 long enabled run with a record of the bits
    for (int i = 0; i < 520; i++) begin
      drive(2000, 100, 1, 1, "R2 R4 R5 run");
      #1 rec[i] = prbs_bit;
    end
    ones = 0;
    for (int i = 0; i < 511; i++) ones += int'(rec[i]);
    check(ones == 256, "R3 ones per period", ones, 256);
    for (int i = 0; i < 9; i++)
      check(rec[i] == rec[i + 511], "R3 period repeat", int'(rec[i + 511]), int'(rec[i]));

    // R9 enabled without a strobe: sequence stays put
    for (int i = 0; i < 4; i++) drive(1500, 20, 0, 1, "R9 no strobe");

    // R6 R7 clamping at both ends, both bit values
    for (int i = 0; i < 12; i++) drive(3990, 200, 1, 1, "R6 high clamp");
    for (int i = 0; i < 12; i++) drive(50, 200, 1, 1, "R7 low clamp");
    drive(4095, 10, 1, 1, "R6 input over full scale");
    drive(0, 4095, 1, 1, "R6 R7 huge amplitude");
    drive(4000, 0, 1, 1, "R6 R4 R5 zero amplitude at top");

    // R8 pause mid-sequence, then resume
    for (int i = 0; i < 5; i++) drive(999, 333, 1, 0, "R8 paused");
    for (int i = 0; i < 20; i++) drive(1000, 40, 1, 1, "R8 resume");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    summary();
    $finish;
  end
endmodule